// File: doc/BRIEF.md
# Peripheral Low-Power Quiesce Controller

This block decides when a serial flash / SPI controller may be powered down. Two separate paths can ask for low power. One is a hardware stop handshake: the power manager raises a request, and the block answers with an acknowledge. The other is a software disable bit, which is written through a small write port. When the disable is granted, the block drops a clock-enable output that feeds an external gating cell.

A request is not granted at once. The block first waits for the datapath to reach a safe point:

- In the serial (SPI) modes, the safe point is the end of the frame now being shifted.
- In flash-command mode, the safe point is the completion of the command now in progress.

The block tracks a command-pending status and exposes it as a busy flag. While the stop acknowledge is high, it holds its interrupt and DMA request outputs frozen. Between a stop request and stop exit, it flags any new command or bus request made in flash-command mode as illegal. The serial shifter, the bus interface and the gating cells sit outside the block. They appear here only as status inputs and enable outputs.

Top module: `lpq_ctrl`

## Requirements
- R1: After reset, stop_ack_o=0, clk_en_o=1, mdis_o=0, busy_o=0, illegal_o=0, quiesced_o=0, and irq_o and dma_o are all zero.
- R2: When no frame and no command blocks entry, stop_ack_o rises on the clock edge that first samples stop_req_i high, which is one cycle after the request.
- R3: In an SPI mode (mode_i = 00, 01 or 10), while xfer_active_i=1 the acknowledge is withheld. It rises on the edge that samples frame_end_i=1, which marks the frame boundary.
- R4: In flash-command mode (mode_i = 11), while a command is pending the acknowledge is withheld. It rises on the edge that samples cmd_done_i=1.
- R5: Once granted, stop_ack_o stays high while stop_req_i stays high. It falls one cycle after stop_req_i goes low.
- R6: With stop_ack_o low, irq_o and dma_o take irq_i and dma_i one cycle later. On every edge where stop_ack_o is high, they keep their values.
- R7: A write with mdis_wr_en_i=1 loads mdis_wr_data_i into mdis_o on the next edge. With mdis_o=1, clk_en_o falls one cycle after the same safe point that R2 to R4 use for stop.
- R8: One cycle after mdis_o reads 0, clk_en_o is 1 again.
- R9: busy_o becomes 1 one cycle after cmd_start_i=1, and 0 one cycle after cmd_done_i=1. If both arrive in the same cycle, start wins.
- R10: In flash-command mode, a cmd_start_i or bus_req_i pulse while stop_req_i or stop_ack_o is high gives illegal_o=1 on the next cycle, for that one cycle. The same pulse in an SPI mode, or outside the stop window, gives no error.
- R11: The stop path and the disable path are granted independently. quiesced_o is high while either grant holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 2 | Datapath mode: 00/01/10 are SPI modes, 11 is flash-command mode |
| xfer_active_i | input | 1 | A serial frame is being shifted |
| frame_end_i | input | 1 | Current frame reaches its boundary this cycle |
| cmd_start_i | input | 1 | A flash command is issued |
| cmd_done_i | input | 1 | The pending flash command completes |
| bus_req_i | input | 1 | A new bus read request arrives |
| stop_req_i | input | 1 | Stop request from the power manager |
| stop_ack_o | output | 1 | Stop acknowledge |
| mdis_wr_en_i | input | 1 | Write strobe for the disable bit |
| mdis_wr_data_i | input | 1 | Value written to the disable bit |
| mdis_o | output | 1 | Readback of the disable bit |
| clk_en_o | output | 1 | Clock enable to the external gate |
| quiesced_o | output | 1 | Either low-power path is granted |
| busy_o | output | 1 | A flash command is pending |
| irq_i | input | IRQ_W | Interrupt requests from the datapath |
| dma_i | input | DMA_W | DMA requests from the datapath |
| irq_o | output | IRQ_W | Interrupt requests, frozen while stopped |
| dma_o | output | DMA_W | DMA requests, frozen while stopped |
| illegal_o | output | 1 | One-cycle pulse on an illegal request during stop |

## Verification
The stop handshake is driven under several conditions, each meant to expose a different fault:

- **Idle datapath.** A grant here must take exactly one cycle, so a missing or extra pipeline stage shows up.
- **SPI frame in flight.** This separates a grant that waits for frame_end_i from one that ignores it.
- **Flash command pending.** The grant must track cmd_done_i, not the serial status.

The disable path is exercised in the same way, both idle and mid-frame. It is then run together with the stop path, to show that the two paths are granted and released independently. Illegal-request pulses are sent in both flash-command and SPI modes, so a guard that ignores the mode is caught.

// File: rtl/lpq_pkg.sv
package lpq_pkg;

  typedef enum logic [1:0] {
    XM_SINGLE   = 2'b00,
    XM_DUAL     = 2'b01,
    XM_QUAD     = 2'b10,
    XM_FLASHCMD = 2'b11
  } xfer_mode_e;

  localparam int unsigned PATH_STOP = 0;
  localparam int unsigned PATH_MDIS = 1;
  localparam int unsigned NUM_PATHS = 2;

  function automatic logic is_cmd_mode(input xfer_mode_e m);
    return (m == XM_FLASHCMD);
  endfunction

endpackage

// File: rtl/lpq_rst_sync.sv
module lpq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_nxt;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/lpq_safe_point.sv
module lpq_safe_point
  import lpq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  xfer_mode_e mode,
  input  logic       xfer_active,
  input  logic       frame_end,
  input  logic       cmd_start,
  input  logic       cmd_done,
  output logic       busy,
  output logic       safe
);
  logic busy_q;
  logic busy_nxt;
  logic busy_en;

  // Command tracker: a new start has priority over completion.
  always_comb begin
    busy_en  = cmd_start | cmd_done;
    busy_nxt = busy_q;
    if (cmd_start)     busy_nxt = 1'b1;
    else if (cmd_done) busy_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy_q <= 1'b0;
    else if (busy_en) busy_q <= busy_nxt;
  end

  // Safe point depends on the active datapath mode.
  always_comb begin
    if (is_cmd_mode(mode)) safe = ~busy_q | cmd_done;
    else                   safe = ~xfer_active | frame_end;
  end

  assign busy = busy_q;
endmodule

// File: rtl/lpq_grant.sv
module lpq_grant (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic safe,
  output logic granted
);
  logic grant_q;
  logic grant_nxt;

  // A grant is taken at a safe point and held until the request drops.
  always_comb begin
    grant_nxt = req & (grant_q | safe);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grant_q <= 1'b0;
    else        grant_q <= grant_nxt;
  end

  assign granted = grant_q;
endmodule

// File: rtl/lpq_hold.sv
module lpq_hold #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         freeze,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic         load_en;

  always_comb begin
    load_en = ~freeze;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_r <= '0;
    else if (load_en) q_r <= d;
  end

  assign q = q_r;
endmodule

// File: rtl/lpq_guard.sv
module lpq_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic window,
  input  logic cmd_mode,
  input  logic cmd_start,
  input  logic bus_req,
  output logic err
);
  logic err_q;
  logic err_nxt;

  always_comb begin
    err_nxt = window & cmd_mode & (cmd_start | bus_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_nxt;
  end

  assign err = err_q;
endmodule

// File: rtl/lpq_ctrl.sv
module lpq_ctrl
  import lpq_pkg::*;
#(
  parameter int unsigned IRQ_W      = 4,
  parameter int unsigned DMA_W      = 2,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             xfer_active_i,
  input  logic             frame_end_i,
  input  logic             cmd_start_i,
  input  logic             cmd_done_i,
  input  logic             bus_req_i,
  input  logic             stop_req_i,
  output logic             stop_ack_o,
  input  logic             mdis_wr_en_i,
  input  logic             mdis_wr_data_i,
  output logic             mdis_o,
  output logic             clk_en_o,
  output logic             quiesced_o,
  output logic             busy_o,
  input  logic [IRQ_W-1:0] irq_i,
  input  logic [DMA_W-1:0] dma_i,
  output logic [IRQ_W-1:0] irq_o,
  output logic [DMA_W-1:0] dma_o,
  output logic             illegal_o
);
  logic           rst_int_n;
  xfer_mode_e     mode;
  logic           safe;
  logic           mdis_q;
  logic           mdis_nxt;
  logic [NUM_PATHS-1:0] path_req;
  logic [NUM_PATHS-1:0] path_grant;
  logic           stop_window;

  lpq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_int_n)
  );

  assign mode = xfer_mode_e'(mode_i);

  lpq_safe_point u_safe (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .mode        (mode),
    .xfer_active (xfer_active_i),
    .frame_end   (frame_end_i),
    .cmd_start   (cmd_start_i),
    .cmd_done    (cmd_done_i),
    .busy        (busy_o),
    .safe        (safe)
  );

  // Software disable bit.
  always_comb begin
    mdis_nxt = mdis_wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)        mdis_q <= 1'b0;
    else if (mdis_wr_en_i) mdis_q <= mdis_nxt;
  end

  // Two independent grant paths sharing one safe-point decision.
  assign path_req[PATH_STOP] = stop_req_i;
  assign path_req[PATH_MDIS] = mdis_q;

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    lpq_grant u_grant (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .req     (path_req[p]),
      .safe    (safe),
      .granted (path_grant[p])
    );
  end

  assign stop_ack_o = path_grant[PATH_STOP];
  assign clk_en_o   = ~path_grant[PATH_MDIS];
  assign quiesced_o = |path_grant;
  assign mdis_o     = mdis_q;

  lpq_hold #(.W(IRQ_W)) u_irq_hold (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .freeze (path_grant[PATH_STOP]),
    .d      (irq_i),
    .q      (irq_o)
  );

  lpq_hold #(.W(DMA_W)) u_dma_hold (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .freeze (path_grant[PATH_STOP]),
    .d      (dma_i),
    .q      (dma_o)
  );

  assign stop_window = stop_req_i | path_grant[PATH_STOP];

  lpq_guard u_guard (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .window    (stop_window),
    .cmd_mode  (is_cmd_mode(mode)),
    .cmd_start (cmd_start_i),
    .bus_req   (bus_req_i),
    .err       (illegal_o)
  );
endmodule

// File: rtl/lpq_ctrl_chk.sv
module lpq_ctrl_chk #(
  parameter int unsigned IRQ_W = 4,
  parameter int unsigned DMA_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_i,
  input logic             cmd_start_i,
  input logic             cmd_done_i,
  input logic             bus_req_i,
  input logic             stop_req_i,
  input logic             stop_ack_o,
  input logic             mdis_o,
  input logic             clk_en_o,
  input logic             busy_o,
  input logic [IRQ_W-1:0] irq_o,
  input logic [DMA_W-1:0] dma_o,
  input logic             illegal_o
);
  a_r2_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_ack_o) |-> $past(stop_req_i));

  a_r4_ack_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stop_ack_o) && $past(mode_i) == 2'b11) |-> ($past(!busy_o) || $past(cmd_done_i)));

  a_r5_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ack_o && !stop_req_i) |=> !stop_ack_o);

  a_r6_irq_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ack_o |=> $stable(irq_o));

  a_r6_dma_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ack_o |=> $stable(dma_o));

  a_r8_clk_en_back: assert property (@(posedge clk) disable iff (!rst_n)
    !mdis_o |=> clk_en_o);

  a_r9_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start_i |=> busy_o);

  a_r10_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> ($past(stop_req_i || stop_ack_o) && $past(mode_i) == 2'b11
                   && $past(cmd_start_i || bus_req_i)));
endmodule

bind lpq_ctrl lpq_ctrl_chk #(.IRQ_W(IRQ_W), .DMA_W(DMA_W)) u_chk (.*);

// File: tb/lpq_ctrl_test.sv
module lpq_ctrl_test;
  localparam int CLK_P = 10;
  localparam int IRQ_W = 4;
  localparam int DMA_W = 2;

  logic             clk;
  logic             rst_n;
  logic [1:0]       mode_i;
  logic             xfer_active_i, frame_end_i, cmd_start_i, cmd_done_i, bus_req_i;
  logic             stop_req_i, stop_ack_o, mdis_wr_en_i, mdis_wr_data_i, mdis_o;
  logic             clk_en_o, quiesced_o, busy_o, illegal_o;
  logic [IRQ_W-1:0] irq_i, irq_o;
  logic [DMA_W-1:0] dma_i, dma_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  lpq_ctrl #(.IRQ_W(IRQ_W), .DMA_W(DMA_W)) uut (.*);

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; mode_i = 2'b00; xfer_active_i = 0; frame_end_i = 0;
    cmd_start_i = 0; cmd_done_i = 0; bus_req_i = 0; stop_req_i = 0;
    mdis_wr_en_i = 0; mdis_wr_data_i = 0; irq_i = '0; dma_i = '0;
    step(3);
    rst_n = 1'b1;
    step(4);
    check("R1 stop_ack", stop_ack_o, 0);
    check("R1 clk_en", clk_en_o, 1);
    check("R1 mdis", mdis_o, 0);
    check("R1 busy", busy_o, 0);
    check("R1 illegal", illegal_o, 0);
    check("R1 quiesced", quiesced_o, 0);
    check("R1 irq/dma", {irq_o, dma_o}, 0);
  endtask

  task automatic t_idle_stop;
    mode_i = 2'b00; stop_req_i = 1;
    check("R2 ack not before edge", stop_ack_o, 0);
    step();
    check("R2 idle grant", stop_ack_o, 1);
    check("R11 quiesced via stop", quiesced_o, 1);
    step(2);
    check("R5 ack held", stop_ack_o, 1);
    stop_req_i = 0;
    step();
    check("R5 ack release", stop_ack_o, 0);
  endtask

  task automatic t_spi_frame;
    mode_i = 2'b10; xfer_active_i = 1; stop_req_i = 1;
    step(3);
    check("R3 ack waits frame", stop_ack_o, 0);
    frame_end_i = 1;
    step();
    check("R3 ack at frame end", stop_ack_o, 1);
    frame_end_i = 0; xfer_active_i = 0; stop_req_i = 0;
    step();
    check("R5 release after frame", stop_ack_o, 0);
  endtask

  task automatic t_cmd_wait;
    mode_i = 2'b11; cmd_start_i = 1;
    step();
    check("R9 busy set", busy_o, 1);
    cmd_start_i = 0; stop_req_i = 1;
    step(2);
    check("R4 ack waits command", stop_ack_o, 0);
    cmd_done_i = 1;
    step();
    check("R4 ack at cmd done", stop_ack_o, 1);
    check("R9 busy cleared", busy_o, 0);
    cmd_done_i = 0; stop_req_i = 0;
    step();
    check("R5 release after cmd", stop_ack_o, 0);
    cmd_start_i = 1; cmd_done_i = 1;
    step();
    check("R9 start wins", busy_o, 1);
    cmd_start_i = 0;
    step();
    check("R9 cleared by done", busy_o, 0);
    cmd_done_i = 0;
    // busy command does not block in SPI mode
    mode_i = 2'b01; cmd_start_i = 1;
    step();
    cmd_start_i = 0; stop_req_i = 1;
    step();
    check("R3 spi ignores command", stop_ack_o, 1);
    stop_req_i = 0; cmd_done_i = 1;
    step();
    cmd_done_i = 0;
  endtask

  task automatic t_freeze;
    mode_i = 2'b00; irq_i = 4'h5; dma_i = 2'h1;
    step();
    check("R6 irq follows", irq_o, 4'h5);
    check("R6 dma follows", dma_o, 2'h1);
    stop_req_i = 1;
    step();
    check("R6 ack up", stop_ack_o, 1);
    irq_i = 4'hA; dma_i = 2'h2;
    step(2);
    check("R6 irq frozen", irq_o, 4'h5);
    check("R6 dma frozen", dma_o, 2'h1);
    stop_req_i = 0;
    step();
    check("R6 irq still held at release", irq_o, 4'h5);
    step();
    check("R6 irq resumes", irq_o, 4'hA);
    check("R6 dma resumes", dma_o, 2'h2);
  endtask

  task automatic t_mdis;
    mode_i = 2'b10; xfer_active_i = 1;
    mdis_wr_en_i = 1; mdis_wr_data_i = 1;
    step();
    mdis_wr_en_i = 0;
    check("R7 bit set", mdis_o, 1);
    check("R7 clk_en kept mid-frame", clk_en_o, 1);
    step();
    check("R7 still waiting frame", clk_en_o, 1);
    frame_end_i = 1;
    step();
    check("R7 clk_en drops at frame end", clk_en_o, 0);
    check("R11 quiesced via disable", quiesced_o, 1);
    frame_end_i = 0; xfer_active_i = 0;
    mdis_wr_en_i = 1; mdis_wr_data_i = 0;
    step();
    mdis_wr_en_i = 0;
    check("R8 bit cleared", mdis_o, 0);
    step();
    check("R8 clk_en back", clk_en_o, 1);
    mdis_wr_en_i = 1; mdis_wr_data_i = 1;
    step();
    mdis_wr_en_i = 0;
    step();
    check("R7 idle disable", clk_en_o, 0);
    mdis_wr_en_i = 1; mdis_wr_data_i = 0;
    step();
    mdis_wr_en_i = 0;
    step();
  endtask

  task automatic t_illegal;
    mode_i = 2'b11; bus_req_i = 1;
    step();
    check("R10 no err outside window", illegal_o, 0);
    bus_req_i = 0; stop_req_i = 1;
    step();
    bus_req_i = 1;
    step();
    check("R10 bus req flagged", illegal_o, 1);
    bus_req_i = 0;
    step();
    check("R10 single pulse", illegal_o, 0);
    mode_i = 2'b00; bus_req_i = 1;
    step();
    check("R10 spi no err", illegal_o, 0);
    bus_req_i = 0; stop_req_i = 0;
    step();
  endtask

  task automatic t_both;
    mode_i = 2'b00; stop_req_i = 1; mdis_wr_en_i = 1; mdis_wr_data_i = 1;
    step();
    mdis_wr_en_i = 0;
    check("R11 stop granted", stop_ack_o, 1);
    step();
    check("R11 disable granted", clk_en_o, 0);
    stop_req_i = 0;
    step();
    check("R11 stop released alone", stop_ack_o, 0);
    check("R11 still quiesced", quiesced_o, 1);
    mdis_wr_en_i = 1; mdis_wr_data_i = 0;
    step();
    mdis_wr_en_i = 0;
    step();
    check("R11 clk_en back", clk_en_o, 1);
    check("R11 not quiesced", quiesced_o, 0);
  endtask

  initial begin
    t_reset();
    t_idle_stop();
    t_spi_frame();
    t_cmd_wait();
    t_freeze();
    t_mdis();
    t_illegal();
    t_both();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule